// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox

This block carries single words between two independently clocked ports without using the FIFO storage. One mailbox carries a word from port A to port B and a second carries a word from port B to port A. The sending port of each mailbox sees a full flag, active low. The flag goes low when the sender deposits a word. It returns high only after the other port has read that word, once the read has crossed back into the sender's clock.

Each port decodes an access from four controls: an active-low chip select, a direction bit (1 = write, 0 = read), an enable and a mailbox select. When mailbox select is low, the port's data output shows the FIFO output register word, which reaches the block on an input. When it is high, the output shows the mailbox that port reads. Reading does not alter the stored word. A write to a mailbox whose flag is still low is dropped, so an unread word cannot be overwritten. Set and clear events cross the clock boundary as toggles through multi-stage synchronizers.

Top module: `mbox_pair`

## Requirements
- R1: On a rising clk_a_i edge where cs_a_ni=0, wr_a_i=1, en_a_i=1, mb_a_i=1 and mb1_full_no=1, mailbox 1 captures data_a_i and mb1_full_no is 0 after that edge. It stays 0 until port B reads the word.
- R2: While mb_b_i=1, data_b_o shows the word held in mailbox 1.
- R3: A port B read of a pending mailbox 1 word (cs_b_ni=0, wr_b_i=0, en_b_i=1, mb_b_i=1 on a rising clk_b_i edge) returns mb1_full_no to 1 by the third rising clk_a_i edge after that read.
- R4: Reading a mailbox does not change its contents, so a second read returns the same word.
- R5: A port A mailbox write while mb1_full_no=0 is ignored: the stored word and the flag both stay as they were.
- R6: Mailbox 2 mirrors mailbox 1. Port B writes it with wr_b_i=1 and mb2_full_no goes low. Port A reads it on data_a_o while mb_a_i=1, and a read with wr_a_i=0 returns mb2_full_no to 1 by the third rising clk_b_i edge.
- R7: While a port's mailbox select is 0, its data output equals its FIFO word input (data_a_o=fifo_a_i, data_b_o=fifo_b_i).
- R8: Reset (rst_ni=0, asynchronous) sets both flags to 1 and both mailbox words to zero.
- R9: A write attempt with the chip select high, the enable low or the mailbox select low changes neither the mailbox word nor its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_a_ni | input | 1 | Port A chip select, active low |
| wr_a_i | input | 1 | Port A direction, 1 = write, 0 = read |
| en_a_i | input | 1 | Port A enable |
| mb_a_i | input | 1 | Port A mailbox select |
| data_a_i | input | DATA_W | Port A write data |
| fifo_a_i | input | DATA_W | FIFO output word presented on port A |
| data_a_o | output | DATA_W | Port A read data |
| mb1_full_no | output | 1 | Mailbox 1 holds an unread word (low), clk_a_i domain |
| cs_b_ni | input | 1 | Port B chip select, active low |
| wr_b_i | input | 1 | Port B direction, 1 = write, 0 = read |
| en_b_i | input | 1 | Port B enable |
| mb_b_i | input | 1 | Port B mailbox select |
| data_b_i | input | DATA_W | Port B write data |
| fifo_b_i | input | DATA_W | FIFO output word presented on port B |
| data_b_o | output | DATA_W | Port B read data |
| mb2_full_no | output | 1 | Mailbox 2 holds an unread word (low), clk_b_i domain |

## Verification
A toggle stuck or flipped in the wrong domain shows as a flag that never returns high after a read, or one that never falls on a write. The first shows within three sender clock edges of the read. The second shows on the edge right after the write. A broken write guard shows as a changed word on the receiving port's next mailbox read. A bad decode or output mux shows at once as the wrong word on a data output in the same cycle the select changes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic put;
    logic get;
  } mbox_req_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $fatal(1, "mbox_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
(
  input  logic      cs_ni,
  input  logic      wr_i,
  input  logic      en_i,
  input  logic      mb_i,
  output mbox_req_t req_o
);
  logic sel;
  assign sel       = ~cs_ni & en_i & mb_i;
  assign req_o.put = sel & wr_i;
  assign req_o.get = sel & ~wr_i;
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              put_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              get_i,
  output logic              full_no,
  output logic [DATA_W-1:0] word_o
);
  logic              put_tog_q, get_tog_q;
  logic              put_tog_r, get_tog_w;
  logic [DATA_W-1:0] word_q;
  logic              free_w, pend_r;

  // writer side: free while both toggles agree
  assign free_w  = (put_tog_q == get_tog_w);
  assign full_no = free_w;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      put_tog_q <= 1'b0;
      word_q    <= '0;
    end else if (put_i && free_w) begin
      put_tog_q <= ~put_tog_q;
      word_q    <= wdata_i;
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_put (
    .clk_i (rclk_i), .rst_ni(rst_ni), .d_i(put_tog_q), .q_o(put_tog_r)
  );

  // reader side: pending once the put toggle has arrived
  assign pend_r = (put_tog_r != get_tog_q);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)                get_tog_q <= 1'b0;
    else if (get_i && pend_r)   get_tog_q <= ~get_tog_q;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_get (
    .clk_i (wclk_i), .rst_ni(rst_ni), .d_i(get_tog_q), .q_o(get_tog_w)
  );

  // word is held stable while pending, so the reader may sample it directly
  assign word_o = word_q;
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              cs_a_ni,
  input  logic              wr_a_i,
  input  logic              en_a_i,
  input  logic              mb_a_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] fifo_a_i,
  output logic [DATA_W-1:0] data_a_o,
  output logic              mb1_full_no,
  input  logic              cs_b_ni,
  input  logic              wr_b_i,
  input  logic              en_b_i,
  input  logic              mb_b_i,
  input  logic [DATA_W-1:0] data_b_i,
  input  logic [DATA_W-1:0] fifo_b_i,
  output logic [DATA_W-1:0] data_b_o,
  output logic              mb2_full_no
);
  mbox_req_t         req_a, req_b;
  logic [DATA_W-1:0] mb1_word, mb2_word;

  mbox_port_dec u_dec_a (
    .cs_ni(cs_a_ni), .wr_i(wr_a_i), .en_i(en_a_i), .mb_i(mb_a_i), .req_o(req_a)
  );
  mbox_port_dec u_dec_b (
    .cs_ni(cs_b_ni), .wr_i(wr_b_i), .en_i(en_b_i), .mb_i(mb_b_i), .req_o(req_b)
  );

  // A -> B
  mbox_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_lane1 (
    .wclk_i (clk_a_i), .rclk_i(clk_b_i), .rst_ni(rst_ni),
    .put_i  (req_a.put), .wdata_i(data_a_i), .get_i(req_b.get),
    .full_no(mb1_full_no), .word_o(mb1_word)
  );

  // B -> A
  mbox_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_lane2 (
    .wclk_i (clk_b_i), .rclk_i(clk_a_i), .rst_ni(rst_ni),
    .put_i  (req_b.put), .wdata_i(data_b_i), .get_i(req_a.get),
    .full_no(mb2_full_no), .word_o(mb2_word)
  );

  assign data_a_o = mb_a_i ? mb2_word : fifo_a_i;
  assign data_b_o = mb_b_i ? mb1_word : fifo_b_i;
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_a_i,
  input logic              clk_b_i,
  input logic              rst_ni,
  input logic              cs_a_ni,
  input logic              wr_a_i,
  input logic              en_a_i,
  input logic              mb_a_i,
  input logic [DATA_W-1:0] data_a_i,
  input logic              mb1_full_no,
  input logic              cs_b_ni,
  input logic              wr_b_i,
  input logic              en_b_i,
  input logic              mb_b_i,
  input logic [DATA_W-1:0] data_b_i,
  input logic              mb2_full_no,
  input logic [DATA_W-1:0] mb1_word,
  input logic [DATA_W-1:0] mb2_word
);
  assert_put_fills_R1: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!cs_a_ni && wr_a_i && en_a_i && mb_a_i && mb1_full_no)
      |=> (!mb1_full_no && mb1_word == $past(data_a_i)));

  assert_flag_fall_cause_R1: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $fell(mb1_full_no) |-> $past(!cs_a_ni && wr_a_i && en_a_i && mb_a_i));

  assert_no_overwrite_R5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !mb1_full_no |=> $stable(mb1_word));

  assert_idle_keeps_flag_R9: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ((cs_a_ni || !en_a_i || !mb_a_i) && mb1_full_no) |=> (mb1_full_no && $stable(mb1_word)));

  assert_mb2_put_fills_R6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!cs_b_ni && wr_b_i && en_b_i && mb_b_i && mb2_full_no)
      |=> (!mb2_full_no && mb2_word == $past(data_b_i)));

  assert_mb2_no_overwrite_R6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !mb2_full_no |=> $stable(mb2_word));
endmodule

bind mbox_pair mbox_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .cs_a_ni(cs_a_ni), .wr_a_i(wr_a_i), .en_a_i(en_a_i), .mb_a_i(mb_a_i),
  .data_a_i(data_a_i), .mb1_full_no(mb1_full_no),
  .cs_b_ni(cs_b_ni), .wr_b_i(wr_b_i), .en_b_i(en_b_i), .mb_b_i(mb_b_i),
  .data_b_i(data_b_i), .mb2_full_no(mb2_full_no),
  .mb1_word(mb1_word), .mb2_word(mb2_word)
);

// File: tb/mbox_pair_tb_top.sv
module mbox_pair_tb_top;
  localparam int DW         = 36;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_B_PER  = 14;
  localparam int WD_CYCLES  = 50000;

  typedef struct packed {
    logic [DW-1:0] word;
    logic [DW-1:0] fifo;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{word: 36'hF_FFFF_FFFF, fifo: 36'h0_0000_0001},
    '{word: 36'h0_0000_0000, fifo: 36'hF_FFFF_FFFE},
    '{word: 36'hA_AAAA_AAAA, fifo: 36'h5_5555_5555},
    '{word: 36'h5_5555_5555, fifo: 36'hA_AAAA_AAAA},
    '{word: 36'h8_0000_0001, fifo: 36'h1_2345_6789}
  };

  logic clk_a = 0, clk_b = 0, rst_ni = 0;
  logic cs_a_ni = 1, wr_a_i = 0, en_a_i = 0, mb_a_i = 0;
  logic cs_b_ni = 1, wr_b_i = 0, en_b_i = 0, mb_b_i = 0;
  logic [DW-1:0] data_a_i = '0, data_b_i = '0, fifo_a_i = '0, fifo_b_i = '0;
  logic [DW-1:0] data_a_o, data_b_o;
  logic mb1_full_no, mb2_full_no;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PER/2)  clk_b = ~clk_b;

  mbox_pair #(.DATA_W(DW)) dut_i (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .cs_a_ni(cs_a_ni), .wr_a_i(wr_a_i), .en_a_i(en_a_i), .mb_a_i(mb_a_i),
    .data_a_i(data_a_i), .fifo_a_i(fifo_a_i), .data_a_o(data_a_o), .mb1_full_no(mb1_full_no),
    .cs_b_ni(cs_b_ni), .wr_b_i(wr_b_i), .en_b_i(en_b_i), .mb_b_i(mb_b_i),
    .data_b_i(data_b_i), .fifo_b_i(fifo_b_i), .data_b_o(data_b_o), .mb2_full_no(mb2_full_no)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_drive(input logic cs_n, input logic wr, input logic en,
                         input logic mb, input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a_ni = cs_n; wr_a_i = wr; en_a_i = en; mb_a_i = mb; data_a_i = d;
    @(negedge clk_a);
    cs_a_ni = 1; wr_a_i = 0; en_a_i = 0; mb_a_i = 0;
  endtask

  task automatic b_drive(input logic cs_n, input logic wr, input logic en,
                         input logic mb, input logic [DW-1:0] d);
    @(negedge clk_b);
    cs_b_ni = cs_n; wr_b_i = wr; en_b_i = en; mb_b_i = mb; data_b_i = d;
    @(negedge clk_b);
    cs_b_ni = 1; wr_b_i = 0; en_b_i = 0; mb_b_i = 0;
  endtask

  task automatic b_get(output logic [DW-1:0] w);
    @(negedge clk_b);
    cs_b_ni = 0; wr_b_i = 0; en_b_i = 1; mb_b_i = 1;
    #1 w = data_b_o;
    @(negedge clk_b);
    cs_b_ni = 1; en_b_i = 0; mb_b_i = 0;
  endtask

  task automatic a_get(output logic [DW-1:0] w);
    @(negedge clk_a);
    cs_a_ni = 0; wr_a_i = 0; en_a_i = 1; mb_a_i = 1;
    #1 w = data_a_o;
    @(negedge clk_a);
    cs_a_ni = 1; en_a_i = 0; mb_a_i = 0;
  endtask

  task automatic wait_a_flag;
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_a);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] w, w2;
    #23 rst_ni = 1;
    // R8 reset state
    @(negedge clk_a);
    mb_a_i = 1; mb_b_i = 1; #1;
    chk(mb1_full_no === 1'b1, "R8 mb1 flag", {35'd0, mb1_full_no}, 36'd1);
    chk(mb2_full_no === 1'b1, "R8 mb2 flag", {35'd0, mb2_full_no}, 36'd1);
    chk(data_b_o === '0, "R8 mb1 word", data_b_o, '0);
    chk(data_a_o === '0, "R8 mb2 word", data_a_o, '0);
    mb_a_i = 0; mb_b_i = 0;

    foreach (VEC[i]) begin
      a_drive(0, 1, 1, 1, VEC[i].word);
      chk(mb1_full_no === 1'b0, "R1 flag low after put", {35'd0, mb1_full_no}, 36'd0);
      repeat (4) @(negedge clk_b);
      fifo_b_i = VEC[i].fifo; #1;
      chk(data_b_o === VEC[i].fifo, "R7 fifo word shown", data_b_o, VEC[i].fifo);
      chk(mb1_full_no === 1'b0, "R1 flag held until read", {35'd0, mb1_full_no}, 36'd0);
      b_get(w);
      chk(w === VEC[i].word, "R2 mailbox word read", w, VEC[i].word);
      wait_a_flag();
      chk(mb1_full_no === 1'b1, "R3 flag back high", {35'd0, mb1_full_no}, 36'd1);
    end

    // R4 non-destructive read
    b_get(w); b_get(w2);
    chk(w2 === w && w === VEC[4].word, "R4 repeated read", w2, VEC[4].word);
    chk(mb1_full_no === 1'b1, "R4 extra read keeps flag", {35'd0, mb1_full_no}, 36'd1);

    // R9 non-selected writes ignored
    a_drive(1, 1, 1, 1, 36'h1_1111_1111);
    a_drive(0, 1, 0, 1, 36'h2_2222_2222);
    a_drive(0, 1, 1, 0, 36'h3_3333_3333);
    chk(mb1_full_no === 1'b1, "R9 flag unchanged", {35'd0, mb1_full_no}, 36'd1);
    b_get(w);
    chk(w === VEC[4].word, "R9 word unchanged", w, VEC[4].word);

    // R5 write to unread mailbox dropped
    a_drive(0, 1, 1, 1, 36'h0_CAFE_0001);
    a_drive(0, 1, 1, 1, 36'h0_DEAD_0002);
    chk(mb1_full_no === 1'b0, "R5 flag still low", {35'd0, mb1_full_no}, 36'd0);
    repeat (4) @(negedge clk_b);
    b_get(w);
    chk(w === 36'h0_CAFE_0001, "R5 first word kept", w, 36'h0_CAFE_0001);
    wait_a_flag();
    chk(mb1_full_no === 1'b1, "R3 flag high after R5 read", {35'd0, mb1_full_no}, 36'd1);

    // R6 mailbox 2
    b_drive(0, 1, 1, 1, 36'h7_0F0F_0F0F);
    chk(mb2_full_no === 1'b0, "R6 mb2 flag low", {35'd0, mb2_full_no}, 36'd0);
    b_drive(0, 1, 1, 1, 36'h0_0000_BAD0);
    repeat (4) @(negedge clk_a);
    fifo_a_i = 36'h9_8765_4321; #1;
    chk(data_a_o === 36'h9_8765_4321, "R7 port A fifo word", data_a_o, 36'h9_8765_4321);
    a_get(w);
    chk(w === 36'h7_0F0F_0F0F, "R6 mb2 word read", w, 36'h7_0F0F_0F0F);
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    chk(mb2_full_no === 1'b1, "R6 mb2 flag high", {35'd0, mb2_full_no}, 36'd1);

    // R8 reset while mailboxes hold words
    a_drive(0, 1, 1, 1, 36'h4_4444_4444);
    b_drive(0, 1, 1, 1, 36'h6_6666_6666);
    #3 rst_ni = 0; mb_a_i = 1; mb_b_i = 1; #2;
    chk(mb1_full_no === 1'b1 && mb2_full_no === 1'b1, "R8 flags in reset",
        {34'd0, mb1_full_no, mb2_full_no}, 36'd3);
    chk(data_b_o === '0 && data_a_o === '0, "R8 words cleared", data_b_o | data_a_o, '0);
    mb_a_i = 0; mb_b_i = 0;
    #7 rst_ni = 1;
    repeat (2) @(negedge clk_a);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule